// File: doc/BRIEF.md
# Wait Mode Fast Wakeup Controller

This block sequences a device into and out of a low-power wait period. Software asks for entry in one of two ways: it sets the wait-mode request bit directly, or it issues a wait-for-event pulse while the low-power-mode enable is high. Entry is refused if any wake source is already active. A refused request raises a sticky error flag, and software clears that flag with a dedicated clear pulse.

While waiting, the block watches 16 external wake pins and two alarm sources, one from a real-time clock and one from a timer. Each pin has its own enable mask bit and its own active-level bit. The pins are brought into the clock domain through a two-flop synchronizer. Each alarm counts only when its own enable bit is set. When a source fires, the block raises the fast-startup and oscillator-restart requests. It holds them until the oscillator reports ready, and then signals that the master clock is ready again.

The flash low-power code can be written at any time. The block captures the code on the edge that accepts an entry, and the captured value is the mode presented to the flash for that whole wait period.

The state machine has four states:
- RUN: normal operation.
- ENTER: a single cycle that hands the flash its mode.
- WAIT: the block waits for a wake source.
- WAKE: the block waits for the oscillator.

The transitions are:
- RUN to ENTER: an accepted entry.
- RUN to RUN: a rejected entry.
- ENTER to WAIT: always, after one cycle.
- WAIT to WAKE: a wake source is active.
- WAKE to RUN: the oscillator reports ready.

Top module: `wait_wake_ctrl`

## Requirements
- R1: After reset the block is in RUN with `mck_ready`=1, `fast_start`=0, `osc_restart`=0, `flash_lp_active`=0, `entry_err`=0 and `flash_lp_mode`=0.
- R2: A `wait_req` pulse with no wake source active is accepted on the next edge. From then on `mck_ready`=0 and `flash_lp_active`=1, and both stay that way until a wake source fires.
- R3: A `wfe_pulse` starts entry only while `lpm_en`=1. With `lpm_en`=0 it has no effect: `mck_ready` stays 1 and `flash_lp_active` stays 0.
- R4: A wake pin i with `wk_mask[i]`=1 wakes the block when its level equals `wk_pol[i]` (1 = active high, 0 = active low). In WAIT, `fast_start` rises on the third rising edge after the pin changes: two synchronizer edges and one state edge.
- R5: A pin whose mask bit is 0, or whose level differs from its polarity bit, leaves the block in WAIT.
- R6: `rtc_alarm` wakes the block only while `rtc_alarm_en`=1, and `tmr_alarm` wakes it only while `tmr_alarm_en`=1. An enabled alarm raises `fast_start` one edge after it is asserted in WAIT.
- R7: In WAKE, `fast_start` and `osc_restart` are both 1 until `osc_ready` is seen. On the edge that samples `osc_ready`=1, the block returns to RUN: `mck_ready`=1, `fast_start`=0 and `osc_restart`=0.
- R8: `flash_lp_mode` takes the value of `flash_lp_cfg` on the edge that accepts an entry and holds it through the wait period. A write made during the wait appears only at the next entry. The codes are 0 standby, 1 deep power-down and 2 idle.
- R9: Code 3 on `flash_lp_cfg` is reserved and is captured as 0 (standby). `flash_lp_mode` never shows 3.
- R10: An entry request made while any enabled source is active is rejected. The block stays in RUN with `mck_ready`=1 and `flash_lp_active`=0, and `entry_err` becomes 1 on the next edge. The flag stays 1 until `err_clr`.
- R11: An `err_clr` pulse clears `entry_err`. When a rejected entry and `err_clr` occur in the same cycle, `entry_err` is 1 afterwards (setting takes priority).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_req | input | 1 | Software wait-mode request pulse |
| wfe_pulse | input | 1 | Wait-for-event pulse |
| lpm_en | input | 1 | Low-power-mode enable; gates `wfe_pulse` |
| wk_in | input | NWAKE | Asynchronous external wake pins |
| wk_pol | input | NWAKE | Active level per pin (1 = high) |
| wk_mask | input | NWAKE | Per-pin wake enable |
| rtc_alarm | input | 1 | Real-time-clock alarm |
| rtc_alarm_en | input | 1 | Enables the RTC alarm as a wake source |
| tmr_alarm | input | 1 | Timer alarm |
| tmr_alarm_en | input | 1 | Enables the timer alarm as a wake source |
| flash_lp_cfg | input | 2 | Flash low-power code for the next wait |
| osc_ready | input | 1 | Oscillator-ready handshake |
| err_clr | input | 1 | Clears the sticky entry error |
| fast_start | output | 1 | Fast-startup request (WAKE) |
| osc_restart | output | 1 | Fast RC oscillator restart request (WAKE) |
| flash_lp_active | output | 1 | Flash low-power mode applied (ENTER, WAIT) |
| flash_lp_mode | output | 2 | Captured flash low-power code |
| mck_ready | output | 1 | Master clock ready status (RUN) |
| entry_err | output | 1 | Sticky rejected-entry flag |

## Verification
The clearing of the error flag and the rejection of a new entry can land in the same cycle. The bench provokes this by holding an enabled wake pin at its active level, then driving `wait_req` and `err_clr` on the same falling edge. It judges the result one edge later: `entry_err` must read 1 and `mck_ready` must still be 1. A second clear on its own must then bring the flag to 0. This shows that setting beats clearing, and that the rejected request never started an entry.

// File: rtl/wwk_pkg.sv
package wwk_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ENTER = 2'd1,
        ST_WAIT  = 2'd2,
        ST_WAKE  = 2'd3
    } wwk_state_e;

    localparam int FL_W = 2;

    typedef enum logic [FL_W-1:0] {
        FL_STANDBY = 2'd0,
        FL_DEEP    = 2'd1,
        FL_IDLE    = 2'd2,
        FL_RSVD    = 2'd3
    } flash_lp_e;

    // reserved code folds onto standby
    function automatic flash_lp_e fl_norm(input logic [FL_W-1:0] code);
        flash_lp_e r;
        unique case (code)
            2'd1:    r = FL_DEEP;
            2'd2:    r = FL_IDLE;
            default: r = FL_STANDBY;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wwk_sync.sv
module wwk_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wwk_wake_eval.sv
module wwk_wake_eval #(
    parameter int NWAKE = 16
) (
    input  logic [NWAKE-1:0] pin_sync,
    input  logic [NWAKE-1:0] pol,
    input  logic [NWAKE-1:0] mask,
    input  logic             rtc_alarm,
    input  logic             rtc_en,
    input  logic             tmr_alarm,
    input  logic             tmr_en,
    output logic             wake_any
);
    logic [NWAKE-1:0] pin_hit;

    for (genvar i = 0; i < NWAKE; i++) begin : g_pin
        assign pin_hit[i] = mask[i] & (pin_sync[i] ~^ pol[i]);
    end

    logic alarm_hit;
    assign alarm_hit = (rtc_alarm & rtc_en) | (tmr_alarm & tmr_en);
    assign wake_any  = (|pin_hit) | alarm_hit;
endmodule

// File: rtl/wwk_flash_latch.sv
module wwk_flash_latch
    import wwk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [FL_W-1:0] cfg,
    output flash_lp_e       mode_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_q <= FL_STANDBY;
        else if (capture) mode_q <= fl_norm(cfg);
    end

    AST_NO_RSVD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != FL_RSVD);  // R9
endmodule

// File: rtl/wwk_fsm.sv
module wwk_fsm
    import wwk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       entry_req,
    input  logic       wake_any,
    input  logic       osc_ready,
    input  logic       err_clr,
    output wwk_state_e state_o,
    output logic       entry_ok,
    output logic       mck_ready,
    output logic       fast_start,
    output logic       osc_restart,
    output logic       flash_lp_active,
    output logic       entry_err
);
    wwk_state_e st, nxt;
    logic       entry_rej;

    always_comb begin
        nxt       = st;
        entry_ok  = 1'b0;
        entry_rej = 1'b0;
        unique case (st)
            ST_RUN: begin
                if (entry_req) begin
                    if (wake_any) begin
                        entry_rej = 1'b1;
                    end else begin
                        entry_ok = 1'b1;
                        nxt      = ST_ENTER;
                    end
                end
            end
            ST_ENTER: nxt = ST_WAIT;
            ST_WAIT:  if (wake_any)  nxt = ST_WAKE;
            ST_WAKE:  if (osc_ready) nxt = ST_RUN;
            default:  nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         entry_err <= 1'b0;
        else if (entry_rej) entry_err <= 1'b1;
        else if (err_clr)   entry_err <= 1'b0;
    end

    always_comb begin
        mck_ready       = 1'b0;
        fast_start      = 1'b0;
        osc_restart     = 1'b0;
        flash_lp_active = 1'b0;
        unique case (st)
            ST_RUN:   mck_ready = 1'b1;
            ST_ENTER: flash_lp_active = 1'b1;
            ST_WAIT:  flash_lp_active = 1'b1;
            ST_WAKE: begin
                fast_start  = 1'b1;
                osc_restart = 1'b1;
            end
            default:  mck_ready = 1'b1;
        endcase
    end

    assign state_o = st;

    AST_ENTER_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_ENTER |=> st == ST_WAIT);  // R2
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && !wake_any) |=> st == ST_WAIT);  // R5
    AST_READY_AFTER_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mck_ready) |-> $past(osc_ready));  // R7
    AST_REJECT_STAYS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && entry_req && wake_any) |=> (st == ST_RUN && entry_err));  // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_err && !err_clr) |=> entry_err);  // R10
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && entry_req && wake_any && err_clr) |=> entry_err);  // R11
endmodule

// File: rtl/wait_wake_ctrl.sv
module wait_wake_ctrl
    import wwk_pkg::*;
#(
    parameter int NWAKE       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wait_req,
    input  logic             wfe_pulse,
    input  logic             lpm_en,
    input  logic [NWAKE-1:0] wk_in,
    input  logic [NWAKE-1:0] wk_pol,
    input  logic [NWAKE-1:0] wk_mask,
    input  logic             rtc_alarm,
    input  logic             rtc_alarm_en,
    input  logic             tmr_alarm,
    input  logic             tmr_alarm_en,
    input  logic [1:0]       flash_lp_cfg,
    input  logic             osc_ready,
    input  logic             err_clr,
    output logic             fast_start,
    output logic             osc_restart,
    output logic             flash_lp_active,
    output logic [1:0]       flash_lp_mode,
    output logic             mck_ready,
    output logic             entry_err
);
    logic [NWAKE-1:0] wk_sync;
    logic             wake_any;
    logic             entry_req;
    logic             entry_ok;
    wwk_state_e       state;
    flash_lp_e        fl_mode;

    // either entry path leads to the same request
    assign entry_req = wait_req | (wfe_pulse & lpm_en);

    wwk_sync #(.W(NWAKE), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (wk_in),
        .q     (wk_sync)
    );

    wwk_wake_eval #(.NWAKE(NWAKE)) u_eval (
        .pin_sync  (wk_sync),
        .pol       (wk_pol),
        .mask      (wk_mask),
        .rtc_alarm (rtc_alarm),
        .rtc_en    (rtc_alarm_en),
        .tmr_alarm (tmr_alarm),
        .tmr_en    (tmr_alarm_en),
        .wake_any  (wake_any)
    );

    wwk_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .entry_req       (entry_req),
        .wake_any        (wake_any),
        .osc_ready       (osc_ready),
        .err_clr         (err_clr),
        .state_o         (state),
        .entry_ok        (entry_ok),
        .mck_ready       (mck_ready),
        .fast_start      (fast_start),
        .osc_restart     (osc_restart),
        .flash_lp_active (flash_lp_active),
        .entry_err       (entry_err)
    );

    wwk_flash_latch u_flash (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (entry_ok),
        .cfg     (flash_lp_cfg),
        .mode_q  (fl_mode)
    );

    assign flash_lp_mode = fl_mode;

    AST_FLASH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WAIT |-> $stable(flash_lp_mode));  // R8
    AST_WFE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !wait_req && wfe_pulse && !lpm_en) |=> state == ST_RUN);  // R3
endmodule

// File: tb/sim_wait_wake_ctrl.sv
`timescale 1ns/1ps
module sim_wait_wake_ctrl;
    localparam int NW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wait_req, wfe_pulse, lpm_en;
    logic [NW-1:0] wk_in, wk_pol, wk_mask;
    logic          rtc_alarm, rtc_alarm_en, tmr_alarm, tmr_alarm_en;
    logic [1:0]    flash_lp_cfg;
    logic          osc_ready, err_clr;
    logic          fast_start, osc_restart, flash_lp_active, mck_ready, entry_err;
    logic [1:0]    flash_lp_mode;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    wait_wake_ctrl #(.NWAKE(NW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .wfe_pulse(wfe_pulse),
        .lpm_en(lpm_en), .wk_in(wk_in), .wk_pol(wk_pol), .wk_mask(wk_mask),
        .rtc_alarm(rtc_alarm), .rtc_alarm_en(rtc_alarm_en),
        .tmr_alarm(tmr_alarm), .tmr_alarm_en(tmr_alarm_en),
        .flash_lp_cfg(flash_lp_cfg), .osc_ready(osc_ready), .err_clr(err_clr),
        .fast_start(fast_start), .osc_restart(osc_restart),
        .flash_lp_active(flash_lp_active), .flash_lp_mode(flash_lp_mode),
        .mck_ready(mck_ready), .entry_err(entry_err)
    );

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic enter_sw();
        wait_req = 1'b1;
        step();
        wait_req = 1'b0;
    endtask

    task automatic wake_finish(input string tag);
        osc_ready = 1'b1;
        step();
        osc_ready = 1'b0;
        chk({tag, " R7 mck_ready after osc"}, mck_ready, 1);
        chk({tag, " R7 fast_start dropped"}, fast_start, 0);
        chk({tag, " R7 osc_restart dropped"}, osc_restart, 0);
    endtask

    task automatic exit_by_rtc(input string tag);
        rtc_alarm_en = 1'b1;
        rtc_alarm    = 1'b1;
        step(2);
        chk({tag, " R6 rtc wake"}, fast_start, 1);
        wake_finish(tag);
        rtc_alarm    = 1'b0;
        rtc_alarm_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 mck_ready", mck_ready, 1);
        chk("R1 fast_start", fast_start, 0);
        chk("R1 osc_restart", osc_restart, 0);
        chk("R1 flash_lp_active", flash_lp_active, 0);
        chk("R1 entry_err", entry_err, 0);
        chk("R1 flash_lp_mode", flash_lp_mode, 0);
    endtask

    task automatic t_sw_entry_pin_high();
        wk_mask = 16'h0020;
        enter_sw();
        chk("R2 mck_ready low", mck_ready, 0);
        chk("R2 flash_lp_active", flash_lp_active, 1);
        step();
        chk("R2 still waiting", mck_ready, 0);
        wk_in[5] = 1'b1;
        step(2);
        chk("R4 not yet awake", fast_start, 0);
        step();
        chk("R4 fast_start on 3rd edge", fast_start, 1);
        chk("R7 osc_restart", osc_restart, 1);
        step(2);
        chk("R7 held without osc_ready", fast_start, 1);
        wake_finish("pin_high");
        chk("R2 flash released", flash_lp_active, 0);
        wk_in[5] = 1'b0;
        wk_mask  = '0;
        step(3);
    endtask

    task automatic t_wfe_gate();
        lpm_en    = 1'b0;
        wfe_pulse = 1'b1;
        step();
        wfe_pulse = 1'b0;
        chk("R3 wfe ignored mck", mck_ready, 1);
        chk("R3 wfe ignored flash", flash_lp_active, 0);
        step();
        chk("R3 wfe ignored later", mck_ready, 1);
        lpm_en    = 1'b1;
        wfe_pulse = 1'b1;
        step();
        wfe_pulse = 1'b0;
        chk("R3 wfe entry", mck_ready, 0);
        exit_by_rtc("wfe");
        lpm_en = 1'b0;
    endtask

    task automatic t_pol_low_and_mask();
        wk_pol[9] = 1'b0;
        wk_in[9]  = 1'b1;
        wk_mask   = 16'h0200;
        step(3);
        enter_sw();
        step();
        wk_in[3] = 1'b1;
        step(4);
        chk("R5 masked pin ignored", fast_start, 0);
        chk("R5 still in wait", mck_ready, 0);
        wk_in[9] = 1'b0;
        step(3);
        chk("R4 active-low wake", fast_start, 1);
        wake_finish("pol_low");
        wk_in[9]  = 1'b1;
        wk_in[3]  = 1'b0;
        wk_mask   = '0;
        wk_pol[9] = 1'b1;
        step(3);
        wk_in[9]  = 1'b0;
        step(3);
    endtask

    task automatic t_timer_alarm();
        enter_sw();
        step();
        tmr_alarm    = 1'b1;
        tmr_alarm_en = 1'b0;
        step(2);
        chk("R6 disabled timer ignored", fast_start, 0);
        tmr_alarm_en = 1'b1;
        step();
        chk("R6 timer wake", fast_start, 1);
        wake_finish("timer");
        tmr_alarm    = 1'b0;
        tmr_alarm_en = 1'b0;
    endtask

    task automatic t_flash_capture();
        flash_lp_cfg = 2'd1;
        enter_sw();
        chk("R8 captured deep", flash_lp_mode, 1);
        flash_lp_cfg = 2'd2;
        step(2);
        chk("R8 held during wait", flash_lp_mode, 1);
        exit_by_rtc("flash1");
        enter_sw();
        chk("R8 next period idle", flash_lp_mode, 2);
        exit_by_rtc("flash2");
        flash_lp_cfg = 2'd3;
        enter_sw();
        chk("R9 reserved as standby", flash_lp_mode, 0);
        exit_by_rtc("flash3");
        flash_lp_cfg = 2'd0;
    endtask

    task automatic t_reject_and_clear();
        wk_mask  = 16'h0020;
        wk_in[5] = 1'b1;
        step(3);
        enter_sw();
        chk("R10 stays run", mck_ready, 1);
        chk("R10 no flash lp", flash_lp_active, 0);
        chk("R10 error set", entry_err, 1);
        step(2);
        chk("R10 error sticky", entry_err, 1);
        err_clr = 1'b1;
        step();
        err_clr = 1'b0;
        chk("R11 clear", entry_err, 0);
        wait_req = 1'b1;
        err_clr  = 1'b1;
        step();
        wait_req = 1'b0;
        err_clr  = 1'b0;
        chk("R11 set beats clear", entry_err, 1);
        chk("R10 collision stays run", mck_ready, 1);
        err_clr = 1'b1;
        step();
        err_clr = 1'b0;
        chk("R11 clear after collision", entry_err, 0);
        wk_in[5] = 1'b0;
        wk_mask  = '0;
        step(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        wait_req = 1'b0; wfe_pulse = 1'b0; lpm_en = 1'b0;
        wk_in = '0; wk_pol = '1; wk_mask = '0;
        rtc_alarm = 1'b0; rtc_alarm_en = 1'b0;
        tmr_alarm = 1'b0; tmr_alarm_en = 1'b0;
        flash_lp_cfg = 2'd0; osc_ready = 1'b0; err_clr = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(3);
        t_reset();
        t_sw_entry_pin_high();
        t_wfe_gate();
        t_pol_low_and_mask();
        t_timer_alarm();
        t_flash_capture();
        t_reject_and_clear();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule